// File: doc/BRIEF.md
# I2C Register-File Target

This block is an I2C target that exposes a small array of byte-wide registers to a bus master. It watches the two bus lines for START, repeated START and STOP. It compares each address byte with a 7-bit address given on an input. When enabled, it also answers the general call address. The block never drives SCL, and it pulls SDA low only through an open-drain enable.

The first byte written after a write-addressed header positions an internal pointer and is not stored. Each later byte goes to the register the pointer selects. A read-addressed header makes the block send bytes from the pointer location, MSB first. The pointer advances after every byte stored or sent and wraps at the array size. A master can therefore do a dummy write that carries only a pointer byte, then issue a repeated START with the read bit set and read back from that location.

Both bus lines pass through a two-flop synchronizer. Edges are detected on the system clock, so the clock must run well above the SCL rate.

Top module: `i2c_regfile_target`

## Requirements
- R1: An address byte whose upper seven bits equal `dev_addr_i` is acknowledged by pulling SDA low for the 9th clock. Bit 0 of that byte selects the direction: 1 means read, 0 means write.
- R2: An address byte that matches nothing gets no acknowledge. The block then keeps SDA released until the next START, including through any bytes that follow.
- R3: The address byte 0x00 (general call, write) is acknowledged only while `gcall_en_i` is high. After it is acknowledged, it behaves as a write header.
- R4: The first byte after a write header is acknowledged and loads the pointer with its value modulo NUM_REGS. No register is written.
- R5: Every later byte of a write transfer is acknowledged and stored at the pointer, and then the pointer advances by one.
- R6: After a read header, including one that follows a repeated START, the block sends the register at the pointer MSB first. The pointer advances by one after each byte sent. A master ACK makes the block send the next byte.
- R7: A master NACK after a sent byte makes the block release SDA. It then stays silent until a START or STOP.
- R8: The pointer wraps from NUM_REGS-1 to 0 on both writes and reads.
- R9: A START or STOP at any bit position aborts the byte in progress. A partly received byte is never stored, and bit counting restarts.
- R10: The SDA enable changes only in the cycle after a detected SCL falling edge. It may also be released when a START or STOP is detected.
- R11: Asynchronous reset clears every register and the pointer, and releases SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| dev_addr_i | input | 7 | Target address to match |
| gcall_en_i | input | 1 | Enables acknowledgement of the general call address |
| sda_oe_o | output | 1 | When high, SDA is pulled low |

## Verification
The bench sweeps every 7-bit address with general call both off and on. A design with a wrong comparator would acknowledge a foreign address or ignore its own, and one that ignored the enable would answer address zero regardless. The bench writes the whole array through pointers that wrap, including a pointer byte above the array size, and reads the data back after a repeated START. A design that stored the pointer byte, skipped the increment after a NACKed final byte or failed to wrap would return shifted data. The bench also aborts transfers with START and STOP partway through a byte, and clocks on after a master NACK. A design that kept a stale bit count, stored a half byte or kept driving after the NACK would corrupt a register or pull SDA low when it should not.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_RD_NEXT
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] raw, synced, prev;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev <= 2'b11;
    else         prev <= synced;
  end

  assign sda_o      = synced[0];
  assign scl_rise_o = synced[1] & ~prev[1];
  assign scl_fall_o = ~synced[1] & prev[1];
  // data edge while clock stays high
  assign start_o    = synced[1] & prev[1] & prev[0] & ~synced[0];
  assign stop_o     = synced[1] & prev[1] & ~prev[0] & synced[0];
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs #(
  parameter int NUM_REGS = 8,
  parameter int PTR_W    = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic [PTR_W-1:0] raddr_i,
  output logic [7:0]       rdata_o
);
  logic [7:0] mem [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem[r] <= '0;
      else if (we_i && waddr_i == PTR_W'(r))   mem[r] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [6:0] dev_addr_i,
  input  logic       gcall_en_i,
  output logic       sda_oe_o
);
  localparam int PTR_W = $clog2(NUM_REGS);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  tgt_state_e state_q;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic [7:0] tx_q, rx_byte, rdata;
  logic [PTR_W-1:0] ptr_q;
  logic rw_q, ptr_pend, reg_we, addr_hit;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign rx_byte  = {shreg, sda_s};
  assign addr_hit = (rx_byte[7:1] == dev_addr_i) || (gcall_en_i && rx_byte == 8'h00);
  assign reg_we   = (state_q == ST_WR) && scl_rise && (bit_cnt == 3'd7) && !ptr_pend
                    && !start_det && !stop_det;

  i2c_tgt_regs #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we), .waddr_i(ptr_q),
    .wdata_i(rx_byte), .raddr_i(ptr_q), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      rw_q     <= 1'b0;
      ptr_pend <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (start_det) begin
      state_q  <= ST_ADDR;
      bit_cnt  <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      bit_cnt  <= '0;
      sda_oe_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: if (scl_rise) begin
          shreg   <= rx_byte[6:0];
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            if (addr_hit) begin
              state_q  <= ST_ADDR_ACK;
              rw_q     <= rx_byte[0];
              ptr_pend <= ~rx_byte[0];
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        // first fall: drive ACK; second fall: ACK slot over
        ST_ADDR_ACK, ST_WR_ACK: if (scl_fall) begin
          if (!sda_oe_o) begin
            sda_oe_o <= 1'b1;
          end else begin
            bit_cnt <= '0;
            if (state_q == ST_ADDR_ACK && rw_q) begin
              state_q  <= ST_RD;
              tx_q     <= rdata;
              sda_oe_o <= ~rdata[7];
            end else begin
              state_q  <= ST_WR;
              sda_oe_o <= 1'b0;
            end
          end
        end
        ST_WR: if (scl_rise) begin
          shreg   <= rx_byte[6:0];
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            state_q <= ST_WR_ACK;
            if (ptr_pend) begin
              ptr_q    <= rx_byte[PTR_W-1:0];
              ptr_pend <= 1'b0;
            end else begin
              ptr_q <= ptr_q + 1'b1;
            end
          end
        end
        ST_RD: if (scl_fall) begin
          if (bit_cnt == 3'd7) begin
            sda_oe_o <= 1'b0;
            state_q  <= ST_RD_ACK;
            ptr_q    <= ptr_q + 1'b1;
          end else begin
            sda_oe_o <= ~tx_q[6];
            tx_q     <= {tx_q[6:0], 1'b0};
            bit_cnt  <= bit_cnt + 3'd1;
          end
        end
        ST_RD_ACK: if (scl_rise) state_q <= sda_s ? ST_IDLE : ST_RD_NEXT;
        ST_RD_NEXT: if (scl_fall) begin
          state_q  <= ST_RD;
          bit_cnt  <= '0;
          tx_q     <= rdata;
          sda_oe_o <= ~rdata[7];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk
  import i2c_tgt_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_rise,
  input logic       scl_fall,
  input logic       sda_s,
  input logic       start_det,
  input logic       stop_det,
  input tgt_state_e state_q,
  input logic [2:0] bit_cnt,
  input logic       sda_oe_o
);
  a_r10_oe_moves_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |->
      ($past(scl_fall) || (!sda_oe_o && $past(start_det || stop_det))));

  a_r9_frame_clears_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det || stop_det) |=> (bit_cnt == 3'd0));

  a_r2_addr_phase_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR || state_q == ST_IDLE) |-> !sda_oe_o);

  a_r7_nack_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_ACK && scl_rise && sda_s && !start_det && !stop_det)
      |=> (state_q == ST_IDLE && !sda_oe_o));

  a_r11_reset_released: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !sda_oe_o);
endmodule

bind i2c_regfile_target i2c_tgt_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_rise(scl_rise), .scl_fall(scl_fall),
  .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
  .state_q(state_q), .bit_cnt(bit_cnt), .sda_oe_o(sda_oe_o)
);

// File: tb/i2c_regfile_target_tb.sv
module i2c_regfile_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int NREG = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [6:0] dev_addr = 7'h2A;
  logic gcall_en = 1'b0;
  logic sda_oe;
  logic sda_bus;
  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [7:0] mem_m [NREG];
  int ptr_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_regfile_target #(.NUM_REGS(NREG)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(m_scl), .sda_i(sda_bus),
    .dev_addr_i(dev_addr), .gcall_en_i(gcall_en), .sda_oe_o(sda_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    wq(); m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    wq(); m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    wq(); m_sda = b; wq(); m_scl = 1'b1; wq(2); m_scl = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    wq(); m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = sda_bus; wq(); m_scl = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(ack);
  endtask

  task automatic get_byte(output logic [7:0] d, input logic m_ack);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(~m_ack);
  endtask

  // write n bytes starting at pointer p; data derived from seed
  task automatic wr_seq(input logic [7:0] p, input int n, input int seed, input string req);
    logic a;
    logic [7:0] d;
    bus_start();
    put_byte({dev_addr, 1'b0}, a); chk({req, " R1 header ack"}, a, 0);
    put_byte(p, a);                chk("R4 pointer byte ack", a, 0);
    ptr_m = p % NREG;
    for (int i = 0; i < n; i++) begin
      d = 8'((seed * 29 + i * 53 + 7) & 8'hFF);
      put_byte(d, a); chk({req, " R5 data ack"}, a, 0);
      mem_m[ptr_m] = d;
      ptr_m = (ptr_m + 1) % NREG;
    end
    bus_stop();
  endtask

  // dummy write of pointer, repeated START, then read n bytes
  task automatic rd_seq(input logic [7:0] p, input int n, input string req);
    logic a;
    logic [7:0] d;
    bus_start();
    put_byte({dev_addr, 1'b0}, a); chk("R1 write header ack", a, 0);
    put_byte(p, a);                chk("R4 pointer byte ack", a, 0);
    ptr_m = p % NREG;
    bus_start();
    put_byte({dev_addr, 1'b1}, a); chk("R6 read header ack", a, 0);
    for (int i = 0; i < n; i++) begin
      get_byte(d, i != n - 1);
      chk(req, d, mem_m[ptr_m]);
      ptr_m = (ptr_m + 1) % NREG;
    end
    bus_stop();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < NREG; i++) mem_m[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk("R11 sda released in reset", sda_oe, 0);
    rst_ni = 1'b1;
    wq(2);

    // R11: registers read zero after reset, direct read from pointer 0
    bus_start();
    put_byte({dev_addr, 1'b1}, a); chk("R6 direct read header ack", a, 0);
    get_byte(d, 1'b1); chk("R11 reg0 reset value", d, 0);
    get_byte(d, 1'b0); chk("R11 reg1 reset value", d, 0);
    bus_stop();

    // R5 / R6: fill whole array, read back after repeated START
    wr_seq(8'd0, NREG, 1, "fill");
    rd_seq(8'd0, NREG, "R6 readback full array");

    // R7: clock a byte after master NACK, target must stay released
    bus_start();
    put_byte({dev_addr, 1'b1}, a); chk("R6 read header ack", a, 0);
    ptr_m = (ptr_m) % NREG;
    get_byte(d, 1'b0); chk("R6 single byte", d, mem_m[ptr_m]);
    ptr_m = (ptr_m + 1) % NREG;
    get_byte(d, 1'b0); chk("R7 silent after NACK", d, 8'hFF);
    chk("R7 sda released", sda_oe, 0);
    bus_stop();

    // R8: pointer byte above range, writes wrap
    wr_seq(8'hFE, 4, 2, "R8 wrap write");
    rd_seq(8'd7, 3, "R8 wrap read");
    rd_seq(8'd5, 5, "R8 wrap read2");

    // R6: direct read continues from current pointer
    bus_start();
    put_byte({dev_addr, 1'b1}, a); chk("R6 header", a, 0);
    for (int i = 0; i < 3; i++) begin
      get_byte(d, i != 2);
      chk("R6 read from held pointer", d, mem_m[ptr_m]);
      ptr_m = (ptr_m + 1) % NREG;
    end
    bus_stop();

    // R1 / R2 / R3: address sweep, general call off then on
    for (int g = 0; g < 2; g++) begin
      gcall_en = g[0];
      for (int ad = 0; ad < 128; ad++) begin
        bus_start();
        put_byte({7'(ad), 1'b0}, a);
        chk((ad == 0) ? "R3 general call" : "R1 R2 address match", a,
            ((7'(ad) == dev_addr) || (g == 1 && ad == 0)) ? 0 : 1);
        bus_stop();
      end
    end

    // R3: general call with read bit is not accepted
    bus_start();
    put_byte(8'h01, a); chk("R3 general call read nack", a, 1);
    bus_stop();

    // R3: general call write stores data
    bus_start();
    put_byte(8'h00, a); chk("R3 gcall header ack", a, 0);
    put_byte(8'd3, a);  chk("R3 gcall pointer ack", a, 0);
    put_byte(8'h5A, a); chk("R3 gcall data ack", a, 0);
    mem_m[3] = 8'h5A;
    bus_stop();
    gcall_en = 1'b0;

    // R2: foreign address followed by bytes: all NACKed, nothing stored
    bus_start();
    put_byte({dev_addr ^ 7'h11, 1'b0}, a); chk("R2 foreign header nack", a, 1);
    put_byte(8'd0, a);  chk("R2 following byte nack", a, 1);
    put_byte(8'hC3, a); chk("R2 following byte nack", a, 1);
    bus_stop();

    // R9: STOP inside address, START inside address, then valid transfer
    bus_start();
    for (int i = 0; i < 4; i++) put_bit(dev_addr[6-i]);
    bus_stop();
    bus_start();
    for (int i = 0; i < 5; i++) put_bit(1'b0);
    bus_start();
    put_byte({dev_addr, 1'b0}, a); chk("R9 header after aborted bits", a, 0);
    put_byte(8'd2, a); chk("R9 pointer ack", a, 0);
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    bus_stop();
    // partial byte must not have been stored
    rd_seq(8'd0, NREG, "R9 no partial store");

    // R1: new device address
    dev_addr = 7'h51;
    bus_start();
    put_byte({7'h2A, 1'b0}, a); chk("R1 old address nack", a, 1);
    bus_stop();
    wr_seq(8'd4, 6, 3, "R1 new addr");
    rd_seq(8'd0, NREG, "R5 final readback");
    chk("R7 idle released at end", sda_oe, 0);

    done = 1;
    finish_run();
  end
endmodule